// File: doc/BRIEF.md
# Triggered Block Ring Capture Controller

This block writes a continuous stream of converter scan results into a circular sample memory. It supports capture before and after an event, in the way an oscilloscope does. Every scan-end strobe carries one transfer: four 12-bit channel words packed into one 48-bit word. The block emits one memory write for each transfer. The ring is split into `N_BLK` blocks of `XFER` transfers each.

Two block engines share the work in ping-pong fashion. Each engine owns an address base and a transfer counter. When the active engine writes the last transfer of its block, the idle engine takes over at the next block address on the very next strobe. The finished engine is then re-armed with the base of the block after that. Because of this, no strobe is lost or written twice at a block boundary. The block count wraps modulo `N_BLK`, so the write address returns to the buffer base after the last block.

A trigger records the index of the block being filled when it arrives. After the trigger, capture continues until the ring has been filled once. It then stops after the write that completes the block just before the recorded index, and reports this with a one-cycle done pulse. A start input clears everything, arms engine 0 at block 0 and engine 1 at block 1, and begins capture.

Top module: `blk_ring_cap`

## Requirements
- R1: After reset, `wr_en_o`, `done_o`, `blk_idx_o` and `act_eng_o` are all 0. Strobes and triggers that arrive before the first start produce no write and no done pulse.
- R2: While capturing, each strobe produces exactly one write, visible on the cycle after the strobe. `wr_data_o` equals `scan_data_i`, with channel 0 in bits 11:0 through channel 3 in bits 47:36. `wr_addr_o` equals block index times `XFER` plus the offset within the block.
- R3: Successive writes use consecutive addresses. After address `N_BLK*XFER-1`, the next write goes to address 0 and `blk_idx_o` returns to 0. `blk_idx_o` advances by one, modulo `N_BLK`, on the cycle that the final write of a block appears.
- R4: `act_eng_o` toggles at every block end at which capture continues. Strobes on back-to-back cycles across a block end each produce one write at consecutive addresses.
- R5: A trigger during pre-trigger capture latches the current block index b. Capture stops after the write that ends block (b-1) mod `N_BLK`. `done_o` pulses for one cycle, together with that write.
- R6: A trigger in the same cycle as the final strobe of block b latches b, not b+1. That strobe is still written, and exactly (`N_BLK`-1)*`XFER` further writes follow until done.
- R7: A trigger while idle, and any trigger after the first one in a capture, has no effect on when capture stops.
- R8: After done, strobes produce no writes until the next start. A start, including one given mid-capture, restarts at address 0, block 0, engine 0, with no trigger recorded.
- R9: A strobe in the same cycle as start is dropped, and no write results from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Clear counters, arm engines, begin capture |
| scan_i | input | 1 | Scan-end strobe, one transfer |
| scan_data_i | input | 48 | Four 12-bit channel samples |
| trig_i | input | 1 | Trigger event |
| wr_en_o | output | 1 | Memory write enable |
| wr_addr_o | output | ADDR_W | Memory write address (transfer index in ring) |
| wr_data_o | output | 48 | Memory write data |
| blk_idx_o | output | BLK_W | Block currently being filled |
| act_eng_o | output | 1 | Engine currently active |
| done_o | output | 1 | One-cycle pulse when capture ends |

## Verification
The block end and the trigger latch can fall in the same clock cycle. The bench provokes this by raising the trigger together with the final strobe of block 0. It then counts writes until done, expecting (N_BLK-1)*XFER writes and a last address at the top of the ring. A second collision, between a block end and the next strobe on the following cycle, is provoked by streaming back-to-back strobes through every boundary and a full wrap. Each write is judged on its address, data, block index and active engine.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int CH_W = 12;
  localparam int N_CH = 4;
  localparam int DW   = CH_W * N_CH;
endpackage

// File: rtl/cap_engine.sv
module cap_engine #(
  parameter int XFER   = 2500,
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  localparam int CNT_W = (XFER > 1) ? $clog2(XFER) : 1;

  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  cnt_q;

  assign last_o = (cnt_q == CNT_W'(XFER - 1));
  assign addr_o = base_q + ADDR_W'(cnt_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      base_q <= base_i;
      cnt_q  <= '0;
    end else if (step_i) begin
      cnt_q <= last_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cap_trig.sv
module cap_trig #(
  parameter int BLK_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic             trig_i,
  input  logic [BLK_W-1:0] blk_i,
  output logic             seen_o,
  output logic [BLK_W-1:0] blk_o
);
  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      seen_o <= 1'b0;
      blk_o  <= '0;
    end else if (trig_i && run_i && !seen_o) begin
      seen_o <= 1'b1;
      blk_o  <= blk_i;
    end
  end
endmodule

// File: rtl/blk_ring_cap.sv
module blk_ring_cap
  import cap_pkg::*;
#(
  parameter int XFER  = 2500,
  parameter int N_BLK = 8,
  localparam int TOT    = XFER * N_BLK,
  localparam int ADDR_W = $clog2(TOT),
  localparam int BLK_W  = (N_BLK > 1) ? $clog2(N_BLK) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              scan_i,
  input  logic [DW-1:0]     scan_data_i,
  input  logic              trig_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DW-1:0]     wr_data_o,
  output logic [BLK_W-1:0]  blk_idx_o,
  output logic              act_eng_o,
  output logic              done_o
);
  function automatic logic [ADDR_W-1:0] blk_base(input logic [BLK_W-1:0] b);
    return ADDR_W'(int'(b) * XFER);
  endfunction

  function automatic logic [BLK_W-1:0] blk_inc(input logic [BLK_W-1:0] b);
    return (b == BLK_W'(N_BLK - 1)) ? '0 : b + 1'b1;
  endfunction

  logic              run_q;
  logic [BLK_W-1:0]  nxt_blk, nxt2_blk;
  logic              go, blk_end, stop;
  logic              trig_seen;
  logic [BLK_W-1:0]  trig_blk;

  logic [ADDR_W-1:0] eng_addr [2];
  logic              eng_last [2];
  logic              eng_load [2];
  logic [ADDR_W-1:0] eng_base [2];
  logic              eng_step [2];

  assign nxt_blk  = blk_inc(blk_idx_o);
  assign nxt2_blk = blk_inc(nxt_blk);
  assign go       = scan_i && run_q && !start_i;
  assign blk_end  = go && eng_last[act_eng_o];
  assign stop     = blk_end && trig_seen && (nxt_blk == trig_blk);

  for (genvar g = 0; g < 2; g++) begin : g_eng
    always_comb begin
      eng_step[g] = go && (act_eng_o == 1'(g));
      if (start_i) begin
        eng_load[g] = 1'b1;
        eng_base[g] = blk_base(BLK_W'(g));
      end else begin
        eng_load[g] = blk_end && !stop && (act_eng_o == 1'(g));
        eng_base[g] = blk_base(nxt2_blk);
      end
    end

    cap_engine #(.XFER(XFER), .ADDR_W(ADDR_W)) u_eng (
      .clk    (clk),
      .rst    (rst),
      .load_i (eng_load[g]),
      .base_i (eng_base[g]),
      .step_i (eng_step[g]),
      .addr_o (eng_addr[g]),
      .last_o (eng_last[g])
    );
  end

  cap_trig #(.BLK_W(BLK_W)) u_trig (
    .clk     (clk),
    .rst     (rst),
    .clear_i (start_i),
    .run_i   (run_q),
    .trig_i  (trig_i),
    .blk_i   (blk_idx_o),
    .seen_o  (trig_seen),
    .blk_o   (trig_blk)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= 1'b0;
      blk_idx_o <= '0;
      act_eng_o <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      done_o    <= 1'b0;
    end else begin
      wr_en_o   <= go;
      wr_addr_o <= eng_addr[act_eng_o];
      wr_data_o <= scan_data_i;
      done_o    <= stop;
      if (start_i) begin
        run_q     <= 1'b1;
        blk_idx_o <= '0;
        act_eng_o <= 1'b0;
      end else if (stop) begin
        run_q <= 1'b0;
      end else if (blk_end) begin
        blk_idx_o <= nxt_blk;
        act_eng_o <= ~act_eng_o;
      end
    end
  end
endmodule

// File: rtl/cap_ring_chk.sv
module cap_ring_chk #(
  parameter int N_BLK  = 8,
  parameter int XFER   = 2500,
  parameter int ADDR_W = 15,
  parameter int BLK_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              wr_en_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [BLK_W-1:0]  blk_idx_o,
  input logic              act_eng_o,
  input logic              done_o
);
  localparam int TOT = N_BLK * XFER;

  logic              start_d, have_prev;
  logic [ADDR_W-1:0] prev_addr, exp_addr;

  assign exp_addr = (prev_addr == ADDR_W'(TOT - 1)) ? '0 : prev_addr + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_d   <= 1'b0;
      have_prev <= 1'b0;
      prev_addr <= '0;
    end else begin
      start_d <= start_i;
      if (start_i || start_d) begin
        have_prev <= 1'b0;
      end else if (wr_en_o) begin
        have_prev <= 1'b1;
        prev_addr <= wr_addr_o;
      end
    end
  end

  // R3: consecutive addresses with wrap
  a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && have_prev && !start_i && !start_d) |-> (wr_addr_o == exp_addr));

  // R2: address stays inside the ring
  a_r2_addr_range: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> (int'(wr_addr_o) < TOT));

  // R3: block index stays inside the ring
  a_r3_blk_range: assert property (@(posedge clk) disable iff (rst)
    int'(blk_idx_o) < N_BLK);

  // R5: done is a single-cycle pulse that coincides with a write
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  a_r5_done_write: assert property (@(posedge clk) disable iff (rst)
    done_o |-> wr_en_o);

  // R4: engine toggles exactly when the block advances (outside start)
  a_r4_eng_toggle: assert property (@(posedge clk) disable iff (rst)
    (!$past(start_i) && (blk_idx_o != $past(blk_idx_o))) |-> (act_eng_o != $past(act_eng_o)));
  a_r4_eng_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(start_i) && (blk_idx_o == $past(blk_idx_o))) |-> (act_eng_o == $past(act_eng_o)));
endmodule

bind blk_ring_cap cap_ring_chk #(
  .N_BLK(N_BLK), .XFER(XFER), .ADDR_W(ADDR_W), .BLK_W(BLK_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start_i   (start_i),
  .wr_en_o   (wr_en_o),
  .wr_addr_o (wr_addr_o),
  .blk_idx_o (blk_idx_o),
  .act_eng_o (act_eng_o),
  .done_o    (done_o)
);

// File: tb/sim_blk_ring_cap.sv
`timescale 1ns/1ps
module sim_blk_ring_cap;
  localparam int XF  = 4;
  localparam int NB  = 4;
  localparam int TOT = XF * NB;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0, scan_i = 1'b0, trig_i = 1'b0;
  logic [47:0] scan_data_i = '0;
  logic        wr_en_o, act_eng_o, done_o;
  logic [3:0]  wr_addr_o;
  logic [47:0] wr_data_o;
  logic [1:0]  blk_idx_o;

  blk_ring_cap #(.XFER(XF), .N_BLK(NB)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .scan_i(scan_i),
    .scan_data_i(scan_data_i), .trig_i(trig_i), .wr_en_o(wr_en_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .blk_idx_o(blk_idx_o),
    .act_eng_o(act_eng_o), .done_o(done_o)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0, seq = 0;
  bit reported = 0;
  int m_run = 0, m_addr = 0, m_blk = 0, m_eng = 0, m_seen = 0, m_tblk = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] mk(input int i);
    return {12'(i * 4 + 3), 12'(i * 4 + 2), 12'(i * 4 + 1), 12'(i * 4)};
  endfunction

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    end
    $finish;
  endtask

  // one strobe, called at a negedge; returns at the next negedge after checking
  task automatic push(input bit trg, input string req);
    int blk, off, nb, e_addr;
    bit wr, last, dn;
    logic [47:0] d;
    d = mk(seq); seq++;
    scan_i = 1'b1; trig_i = trg; scan_data_i = d;
    wr = (m_run != 0); dn = 0; e_addr = m_addr;
    if (wr) begin
      blk = m_addr / XF; off = m_addr % XF; nb = (blk + 1) % NB;
      last = (off == XF - 1);
      dn = last && (m_seen != 0) && (nb == m_tblk);
      if (trg && m_seen == 0) begin m_seen = 1; m_tblk = blk; end
      m_addr = (m_addr + 1) % TOT;
      if (dn) m_run = 0;
      else if (last) begin m_blk = nb; m_eng ^= 1; end
    end
    @(negedge clk);
    scan_i = 1'b0; trig_i = 1'b0;
    check(wr_en_o == wr, {req, " wr_en"}, wr_en_o, wr);
    if (wr) begin
      check(wr_addr_o == 4'(e_addr), {req, " addr"}, wr_addr_o, e_addr);
      check(wr_data_o == d, {req, " data"}, wr_data_o, d);
    end
    check(done_o == dn, {req, " done"}, done_o, dn);
    check(blk_idx_o == 2'(m_blk), {req, " blk"}, blk_idx_o, m_blk);
    check(act_eng_o == 1'(m_eng), {req, " eng"}, act_eng_o, m_eng);
  endtask

  task automatic trig_only();
    trig_i = 1'b1;
    if (m_run != 0 && m_seen == 0) begin m_seen = 1; m_tblk = m_blk; end
    @(negedge clk);
    trig_i = 1'b0;
    check(wr_en_o == 1'b0, "R7 trigger alone writes", wr_en_o, 0);
  endtask

  task automatic do_start(input bit with_scan);
    start_i = 1'b1; scan_i = with_scan;
    @(negedge clk);
    start_i = 1'b0; scan_i = 1'b0;
    m_run = 1; m_addr = 0; m_blk = 0; m_eng = 0; m_seen = 0; m_tblk = 0;
    check(wr_en_o == 1'b0, with_scan ? "R9 strobe with start dropped" : "R8 start no write", wr_en_o, 0);
    check(blk_idx_o == 2'd0, "R8 start blk", blk_idx_o, 0);
    check(act_eng_o == 1'b0, "R8 start eng", act_eng_o, 0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(wr_en_o == 1'b0, "R2 no strobe no write", wr_en_o, 0);
    end
  endtask

  task automatic t_reset();
    check(wr_en_o == 1'b0, "R1 reset wr_en", wr_en_o, 0);
    check(done_o == 1'b0, "R1 reset done", done_o, 0);
    check(blk_idx_o == 2'd0, "R1 reset blk", blk_idx_o, 0);
    check(act_eng_o == 1'b0, "R1 reset eng", act_eng_o, 0);
    for (int i = 0; i < 3; i++) push(1'b1, "R1 idle strobe");
  endtask

  task automatic t_stream();
    do_start(1'b0);
    for (int i = 0; i < TOT + 3; i++) push(1'b0, "R4 back-to-back");
    check(m_addr == 3, "R3 wrap reached", m_addr, 3);
  endtask

  task automatic t_gapped();
    for (int i = 0; i < 6; i++) begin
      push(1'b0, "R2 gapped");
      idle(2);
    end
  endtask

  task automatic t_trig();
    int writes, last_a;
    bit got;
    do_start(1'b0);
    for (int i = 0; i < 6; i++) push(1'b0, "R5 pre-trigger");
    trig_only();                       // latched at block 1, 2 written in it
    writes = 0; got = 0; last_a = -1;
    for (int i = 0; i < 20 && !got; i++) begin
      if (i == 5) trig_only();         // second trigger must be ignored
      push(1'b0, "R5 post-trigger");
      writes++; last_a = wr_addr_o; got = done_o;
    end
    check(got && writes == 14, "R5 R7 writes until done", writes, 14);
    check(last_a == 3, "R5 last address", last_a, 3);
    for (int i = 0; i < 3; i++) push(1'b0, "R8 after done");
  endtask

  task automatic t_same();
    int writes, last_a;
    bit got;
    do_start(1'b0);
    for (int i = 0; i < 3; i++) push(1'b0, "R6 fill");
    push(1'b1, "R6 trigger on block end");
    writes = 0; got = 0; last_a = -1;
    for (int i = 0; i < 20 && !got; i++) begin
      push(1'b0, "R6 post");
      writes++; last_a = wr_addr_o; got = done_o;
    end
    check(got && writes == (NB - 1) * XF, "R6 writes until done", writes, (NB - 1) * XF);
    check(last_a == TOT - 1, "R6 last address", last_a, TOT - 1);
  endtask

  task automatic t_restart();
    do_start(1'b0);
    for (int i = 0; i < 5; i++) push(1'b0, "R8 run");
    do_start(1'b1);
    push(1'b0, "R8 restart at zero");
    check(wr_addr_o == 4'd0, "R8 restart address", wr_addr_o, 0);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    trig_only();
    t_stream();
    t_gapped();
    t_trig();
    t_same();
    t_restart();
    idle(2);
    report();
  end
endmodule